// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small stored-program processor. Instructions and data sit in one memory, which it reaches through a single port that moves one word per access. A control state machine runs each instruction as a fixed series of phases. It first fetches the instruction word and decodes it. It then fetches any address words that follow, reads the operands and executes. Where the instruction has a result to write, it ends with a store.

The processor keeps a program counter, a memory address register, a memory data register, an instruction register, an accumulator and a few scratch registers. None of these is visible outside. Software observes only the memory contents and the halt flag. Every access goes over the one port, so an instruction's run time depends on how many memory accesses it needs. The memory-to-memory add is the longest instruction: it reads three instruction words and two operands, then writes one result.

Top module: `sbus_acc_cpu`

## Requirements
- R1: Reset (synchronous, active high) clears the program counter and the address register. While reset is held, both strobes and `halted` stay low. In the first cycle after reset the processor reads address 0.
- R2: An instruction word carries its opcode in bits [15:12], and its low 12 bits are ignored. An operand address is the low 8 bits of the word that follows the opcode word, and its upper bits are ignored. The program counter advances by one for every instruction or address word fetched, wrapping at 256. LOAD (opcode 1, one address word X) copies mem[X] into the accumulator.
- R3: STORE (opcode 2, one address word X) writes the accumulator to mem[X].
- R4: ADD (opcode 3, address words A then B) reads mem[A] and then mem[B], and writes their sum modulo 2^16 back to mem[A]. The accumulator is left unchanged. When A equals B the location is doubled.
- R5: JUMP (opcode 4, one address word T) continues execution at address T. Words between the jump and T are never executed.
- R6: Opcode 0 and every undefined opcode (5 to 15) halt the processor. `halted` then stays high, and neither strobe is asserted again until reset.
- R7: At most one strobe is active in any cycle. The cycle after a read strobe carries no strobe, because read data returns one cycle after the address.
- R8: Bus accesses per instruction are as follows: LOAD makes 3 reads; STORE makes 2 reads and 1 write; ADD makes 5 reads and 1 write; JUMP makes 2 reads; a halting word makes 1 read. Each access lasts exactly one cycle.
- R9: Cycles per instruction are 14 for LOAD, 11 for STORE, 24 for ADD and 10 for JUMP. A halting word raises `halted` 5 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW (8) | Address for the current access |
| mem_wdata | output | DW (16) | Data to be written |
| mem_rdata | input | DW (16) | Read data, valid the cycle after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halting opcode has been decoded |

## Verification
Random programs mix LOAD, STORE, ADD and forward JUMP in arbitrary orders. They use random data, random filler in the ignored bits and a random halting opcode at the end. An instruction-level model predicts the final memory, the total cycle count and the read and write counts. Memory compares show whether each instruction has the right effect, and cycle and access totals catch an extra or missing phase even when the data comes out right. Directed programs cover 16-bit wraparound in ADD, an ADD whose two operands share an address, an accumulator that must survive an ADD, jumps over halting words, and an undefined opcode at address 0.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_JUMP  = 4'h4
    } opcode_e;

    typedef enum logic [4:0] {
        S_FETCH_A,
        S_FETCH_R,
        S_FETCH_L,
        S_LOAD_IR,
        S_DECODE,
        S_WORD_A,
        S_WORD_R,
        S_WORD_L,
        S_WORD_PUT,
        S_DATA_A,
        S_DATA_R,
        S_DATA_L,
        S_DATA_PUT,
        S_EXEC,
        S_STORE_A,
        S_STORE_W,
        S_HALT
    } st_e;

    function automatic logic op_known(logic [OPC_W-1:0] op);
        logic k;
        case (op)
            OP_LOAD, OP_STORE, OP_ADD, OP_JUMP: k = 1'b1;
            default:                            k = 1'b0;
        endcase
        return k;
    endfunction

    function automatic logic is_read_state(st_e s);
        return (s == S_FETCH_R) || (s == S_WORD_R) || (s == S_DATA_R);
    endfunction

endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir_op,
    output st_e              st,
    output logic             step
);

    st_e  st_n;
    logic step_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_FETCH_A;
            step <= 1'b0;
        end else begin
            st   <= st_n;
            step <= step_n;
        end
    end

    always_comb begin
        st_n   = st;
        step_n = step;
        case (st)
            S_FETCH_A: st_n = S_FETCH_R;
            S_FETCH_R: st_n = S_FETCH_L;
            S_FETCH_L: st_n = S_LOAD_IR;
            S_LOAD_IR: st_n = S_DECODE;
            S_DECODE: begin
                step_n = 1'b0;
                st_n   = op_known(ir_op) ? S_WORD_A : S_HALT;
            end
            S_WORD_A: st_n = S_WORD_R;
            S_WORD_R: st_n = S_WORD_L;
            S_WORD_L: st_n = S_WORD_PUT;
            S_WORD_PUT: begin
                if (ir_op == OP_ADD && !step) begin
                    step_n = 1'b1;
                    st_n   = S_WORD_A;
                end else begin
                    step_n = 1'b0;
                    case (ir_op)
                        OP_LOAD, OP_ADD: st_n = S_DATA_A;
                        OP_STORE:        st_n = S_STORE_A;
                        default:         st_n = S_EXEC;
                    endcase
                end
            end
            S_DATA_A: st_n = S_DATA_R;
            S_DATA_R: st_n = S_DATA_L;
            S_DATA_L: st_n = S_DATA_PUT;
            S_DATA_PUT: begin
                if (ir_op == OP_ADD && !step) begin
                    step_n = 1'b1;
                    st_n   = S_DATA_A;
                end else begin
                    st_n = S_EXEC;
                end
            end
            S_EXEC:    st_n = (ir_op == OP_ADD) ? S_STORE_A : S_FETCH_A;
            S_STORE_A: st_n = S_STORE_W;
            S_STORE_W: st_n = S_FETCH_A;
            default:   st_n = S_HALT;
        endcase
    end

    // R6: a decoded undefined opcode never leads to further instruction fetch
    a_r6_decode_exit: assert property (@(posedge clk) disable iff (rst)
        (st == S_DECODE && !op_known(ir_op)) |=> (st == S_HALT));

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  st_e              st,
    input  logic             step,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [OPC_W-1:0] ir_op
);

    logic [AW-1:0]    pc_q, mar_q, addr_a_q, addr_b_q;
    logic [DW-1:0]    mdr_q, acc_q, tmp_q;
    logic [OPC_W-1:0] ir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            mar_q    <= '0;
            addr_a_q <= '0;
            addr_b_q <= '0;
            mdr_q    <= '0;
            acc_q    <= '0;
            tmp_q    <= '0;
            ir_q     <= '0;
        end else begin
            case (st)
                S_FETCH_A, S_WORD_A: begin
                    mar_q <= pc_q;
                    pc_q  <= pc_q + 1'b1;
                end
                S_FETCH_L, S_WORD_L, S_DATA_L: mdr_q <= mem_rdata;
                S_LOAD_IR: ir_q <= mdr_q[DW-1 -: OPC_W];
                S_WORD_PUT: begin
                    if (step) addr_b_q <= mdr_q[AW-1:0];
                    else      addr_a_q <= mdr_q[AW-1:0];
                end
                S_DATA_A: mar_q <= step ? addr_b_q : addr_a_q;
                S_DATA_PUT: begin
                    if (ir_q == OP_ADD && !step) tmp_q <= mdr_q;
                end
                S_EXEC: begin
                    case (ir_q)
                        OP_LOAD: acc_q <= mdr_q;
                        OP_ADD:  mdr_q <= tmp_q + mdr_q;
                        OP_JUMP: pc_q  <= addr_a_q;
                        default: ;
                    endcase
                end
                S_STORE_A: begin
                    mar_q <= addr_a_q;
                    if (ir_q == OP_STORE) mdr_q <= acc_q;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign ir_op     = ir_q;

    // R2: the instruction read uses the old PC and the PC moves on by one
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH_R) |-> (mem_addr == $past(pc_q)) && (pc_q == AW'($past(pc_q) + 1'b1)));

    // R3: a STORE puts the accumulator on the write data lines
    a_r3_store_data: assert property (@(posedge clk) disable iff (rst)
        (st == S_STORE_W && ir_q == OP_STORE) |-> (mem_wdata == acc_q));

    // R4: every write lands on the first operand address
    a_r4_write_target: assert property (@(posedge clk) disable iff (rst)
        (st == S_STORE_W) |-> (mem_addr == addr_a_q));

endmodule

// File: rtl/sbus_acc_cpu.sv
module sbus_acc_cpu
    import sbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          halted
);

    st_e              st;
    logic             step;
    logic [OPC_W-1:0] ir_op;

    sbus_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .ir_op (ir_op),
        .st    (st),
        .step  (step)
    );

    sbus_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .step      (step),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_op     (ir_op)
    );

    assign mem_rd = is_read_state(st);
    assign mem_wr = (st == S_STORE_W);
    assign halted = (st == S_HALT);

    // R7: one access at a time on the shared bus
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R7: a read is followed by a quiet cycle while data returns
    a_r7_read_gap: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd && !mem_wr);

    // R8: a write occupies a single cycle
    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R6: halt is sticky and silences the bus
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && !mem_rd && !mem_wr);

endmodule

// File: tb/sbus_acc_cpu_bench.sv
module sbus_acc_cpu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd, mem_wr, halted;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    logic [15:0] mem  [0:255];
    logic [15:0] img  [0:255];
    logic [15:0] refm [0:255];

    int nchk = 0;
    int nfail = 0;
    int rd_cnt, wr_cnt, bus_bad;
    logic prev_rd;
    int exp_cyc, exp_rd, exp_wr;

    always #4 clk = ~clk;

    sbus_acc_cpu u_sbus_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (mem_wr) mem[mem_addr] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            rd_cnt  <= 0;
            wr_cnt  <= 0;
            bus_bad <= 0;
            prev_rd <= 1'b0;
        end else begin
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if ((mem_rd && mem_wr) || (prev_rd && (mem_rd || mem_wr)))
                bus_bad <= bus_bad + 1;
            prev_rd <= mem_rd;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    task automatic run_model();
        logic [7:0]  pc, a, b;
        logic [15:0] w, acc;
        bit done;
        for (int i = 0; i < 256; i++) refm[i] = img[i];
        pc = 8'd0; acc = 16'd0; done = 1'b0;
        exp_cyc = 0; exp_rd = 0; exp_wr = 0;
        for (int k = 0; k < 200 && !done; k++) begin
            w = refm[pc]; pc = pc + 8'd1; exp_rd += 1; exp_cyc += 5;
            case (w[15:12])
                4'h1: begin
                    a = refm[pc][7:0]; pc = pc + 8'd1;
                    acc = refm[a]; exp_rd += 2; exp_cyc += 9;
                end
                4'h2: begin
                    a = refm[pc][7:0]; pc = pc + 8'd1;
                    refm[a] = acc; exp_rd += 1; exp_wr += 1; exp_cyc += 6;
                end
                4'h3: begin
                    a = refm[pc][7:0]; pc = pc + 8'd1;
                    b = refm[pc][7:0]; pc = pc + 8'd1;
                    refm[a] = refm[a] + refm[b];
                    exp_rd += 4; exp_wr += 1; exp_cyc += 19;
                end
                4'h4: begin
                    pc = refm[pc][7:0]; exp_rd += 1; exp_cyc += 5;
                end
                default: done = 1'b1;
            endcase
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    endtask

    task automatic load_and_run(input string tag);
        int cyc, mism, first_bad, r0, w0;
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = img[i];
            @(posedge clk); #1;
        end
        ld_en = 1'b0;
        @(posedge clk); #1;
        check(!mem_rd && !mem_wr && !halted && mem_addr == 8'd0, "R1",
              "reset outputs", {mem_rd, mem_wr, halted}, 0);
        run_model();
        rst = 1'b0;
        @(posedge clk); #1;
        cyc = 1;
        check(mem_rd && mem_addr == 8'd0, "R1", "first fetch address",
              int'(mem_addr), 0);
        while (!halted && cyc < 4000) begin
            @(posedge clk); #1;
            cyc++;
        end
        check(halted, "R6", "halted after program", int'(halted), 1);
        check(cyc == exp_cyc, "R9", "cycles to halt", cyc, exp_cyc);
        check(rd_cnt == exp_rd, "R8", "read accesses", rd_cnt, exp_rd);
        check(wr_cnt == exp_wr, "R8", "write accesses", wr_cnt, exp_wr);
        check(bus_bad == 0, "R7", "bus strobe violations", bus_bad, 0);
        mism = 0; first_bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== refm[i]) begin
                if (mism == 0) first_bad = i;
                mism++;
            end
        end
        check(mism == 0, tag, "memory image",
              int'(mem[first_bad]), int'(refm[first_bad]));
        r0 = rd_cnt; w0 = wr_cnt;
        repeat (8) begin @(posedge clk); #1; end
        check(halted && rd_cnt == r0 && wr_cnt == w0, "R6", "quiet after halt",
              rd_cnt - r0 + wr_cnt - w0, 0);
    endtask

    function automatic logic [15:0] daddr();
        return {8'($urandom), 2'b10, 6'($urandom)};
    endfunction

    task automatic gen_random();
        int p, n, r;
        clear_img();
        for (int i = 128; i < 256; i++) img[i] = 16'($urandom);
        p = 0;
        n = 1 + int'($urandom % 10);
        for (int k = 0; k < n; k++) begin
            r = int'($urandom % 4);
            case (r)
                0: begin
                    img[p] = {4'h1, 12'($urandom)}; img[p+1] = daddr(); p += 2;
                end
                1: begin
                    img[p] = {4'h2, 12'($urandom)}; img[p+1] = daddr(); p += 2;
                end
                2: begin
                    img[p] = {4'h3, 12'($urandom)}; img[p+1] = daddr();
                    img[p+2] = daddr(); p += 3;
                end
                default: begin
                    img[p] = {4'h4, 12'($urandom)};
                    img[p+1] = {8'($urandom), 8'(p + 3)};
                    img[p+2] = 16'h0000; p += 3;
                end
            endcase
        end
        if ($urandom % 2 == 0) img[p] = {4'h0, 12'($urandom)};
        else                   img[p] = {4'(5 + ($urandom % 11)), 12'($urandom)};
    endtask

    initial begin
        #(8 * 190000);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20517));

        // R4: wraparound, doubling with A==B, accumulator kept across ADD (R2 LOAD, R3 STORE)
        clear_img();
        img[0] = 16'h1ABC; img[1] = 16'h0082;
        img[2] = 16'h3000; img[3] = 16'hFF80; img[4] = 16'h0081;
        img[5] = 16'h3555; img[6] = 16'h0084; img[7] = 16'h0084;
        img[8] = 16'h2000; img[9] = 16'h0083;
        img[10] = 16'h0000;
        img[8'h80] = 16'hFFF0; img[8'h81] = 16'h0025;
        img[8'h82] = 16'h1234; img[8'h84] = 16'h8001;
        load_and_run("R4");
        check(mem[8'h80] == 16'h0015, "R4", "sum wraps mod 2^16", int'(mem[8'h80]), 16'h0015);
        check(mem[8'h84] == 16'h0002, "R4", "A==B doubles", int'(mem[8'h84]), 16'h0002);
        check(mem[8'h83] == 16'h1234, "R4", "accumulator kept", int'(mem[8'h83]), 16'h1234);

        // R6: undefined opcode at address 0
        clear_img();
        img[0] = 16'hF123;
        load_and_run("R6");

        // R5: jumps skip halting words
        clear_img();
        img[0] = 16'h1000; img[1] = 16'h0090;
        img[2] = 16'h4000; img[3] = 16'h3340;
        img[8'h40] = 16'h4FFF; img[8'h41] = 16'h0050;
        img[8'h50] = 16'h2000; img[8'h51] = 16'h0091;
        img[8'h52] = 16'h7000;
        img[8'h90] = 16'hBEEF;
        load_and_run("R5");
        check(mem[8'h91] == 16'hBEEF, "R5", "jumped code ran", int'(mem[8'h91]), 16'hBEEF);

        // R2 R3 R4 R5: random programs against the model
        for (int t = 0; t < 20; t++) begin
            gen_random();
            load_and_run("R2");
        end

        finish_up();
    end

endmodule